// File: doc/BRIEF.md
# Power-Stage Fault Supervisor

This block supervises a four-half-bridge class-D output stage. It receives raw comparator flags (overcurrent on every power FET, a temperature warning, a temperature shutdown and undervoltage on each watched supply), an active-low bridge reset, a bridge-mode select and a strobe that marks the start of each PWM period. From these it decides, cycle by cycle, whether the half-bridges may switch or must float in Hi-Z. It also drives the active-low fault line, the weak pulldowns, a truncation signal for the modulator and a temperature warning.

Overcurrent is handled in two tiers. First, each period in which overcurrent appears is cut short. If overcurrent shows up in enough consecutive periods, all four half-bridges are shut down and held off until the bridge reset goes low and high again. A temperature shutdown is also held until a bridge reset. Undervoltage releases on its own once every supply is good again, and it also wipes any held overcurrent shutdown, in the same way a power-on reset would. All flag inputs and the bridge reset are asynchronous and pass through two-flop synchronizers. The PWM strobe is synchronous to `clk`.

Top module: `pstage_guard`

## Requirements
- R1: When undervoltage, a temperature shutdown or a held overcurrent shutdown is active, every half-bridge is disabled (`hb_en` all 0, `hb_hiz` all 1) and `fault_n` is 0. Outputs follow a raw flag change within 3 clock edges.
- R2: While the bridges switch, any overcurrent flag drives `cl_trunc` high at once. `cl_trunc` stays high until the next `pwm_strobe` in which no overcurrent is present. This limiting alone neither disables a bridge nor lowers `fault_n`.
- R3: Overcurrent in `CL_LIMIT` (default 8) consecutive PWM periods shuts down all four half-bridges and drives `fault_n` low. A period counts when overcurrent was seen between its opening strobe and its closing strobe. While shut down, `cl_trunc` is 0.
- R4: A PWM period with no overcurrent resets the consecutive-period count. After such a period, `CL_LIMIT`-1 overloaded periods do not cause a shutdown.
- R5: An overcurrent shutdown persists after the overcurrent flags clear, across any number of strobes. It is released only when `bridge_rst_n` goes low and then high.
- R6: `temp_warn` is 1 while the warning flag is 1. The warning has no effect on `hb_en` or `fault_n`.
- R7: A temperature shutdown stays in force after its flag clears, until `bridge_rst_n` is taken low. After `bridge_rst_n` returns high, switching resumes.
- R8: Undervoltage on any supply flag (`uv_flag` bit = 1 means low) disables the bridges. Switching resumes once every bit is 0, with no bridge reset needed.
- R9: While `bridge_rst_n` is 0, all half-bridges are in Hi-Z and `fault_n` is 1, whatever flags are present.
- R10: `pulldown_en` is all 1 only while the bridge reset is held and `se_mode` is 0 (bridge-tied load). When `se_mode` is 1 it is all 0.
- R11: Undervoltage clears an overcurrent shutdown. Once the supplies recover, switching resumes without a bridge reset.
- R12: While `rst_n` is 0, the outputs read: `hb_en` 0, `hb_hiz` all 1, `pulldown_en` all 1, `fault_n` 1, `temp_warn` 0, `cl_trunc` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous active-low logic reset |
| bridge_rst_n | input | 1 | Asynchronous active-low bridge reset; a low-high cycle releases held shutdowns |
| se_mode | input | 1 | 1 = single-ended outputs, 0 = bridge-tied load |
| oc_flag | input | 2*N_HB | Raw overcurrent flag per power FET |
| otw_flag | input | 1 | Raw over-temperature warning flag |
| ots_flag | input | 1 | Raw over-temperature shutdown flag |
| uv_flag | input | N_SUP | Raw undervoltage flag per supply, 1 = below threshold |
| pwm_strobe | input | 1 | One-cycle pulse at each PWM period start |
| hb_en | output | N_HB | Half-bridge switching enable |
| hb_hiz | output | N_HB | Half-bridge Hi-Z command |
| pulldown_en | output | N_HB | Weak output pulldown enable |
| cl_trunc | output | 1 | Cut the current PWM period short |
| temp_warn | output | 1 | Active-high temperature warning |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The assertions assume that `pwm_strobe` is a single-cycle pulse that is already synchronous to `clk`. They also assume that each raw flag stays at a level long enough to pass the two-flop synchronizers, so that the synchronized view matches what the bench drove. The bench changes flags and strobes only on falling clock edges. Every strobe lasts exactly one cycle and is followed by at least three idle cycles. Flags are held for several cycles before any output is read, so no check lands inside the synchronizer latency.

// File: rtl/pstage_guard_pkg.sv
// Shared types for the power-stage fault supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package pstage_guard_pkg;

    // Supervisor states; held shutdowns each have their own state
    typedef enum logic [2:0] {
        ST_IN_RESET      = 3'd0,
        ST_RUN           = 3'd1,
        ST_CURRENT_LIMIT = 3'd2,
        ST_OC_LATCHED    = 3'd3,
        ST_OT_LATCHED    = 3'd4,
        ST_UV_HOLD       = 3'd5
    } guard_state_e;

endpackage

// File: rtl/flag_sync.sv
// Two-flop synchronizer bank for asynchronous level flags.
// Assumes: inputs are levels held for several clocks; reset value is 0.
module flag_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;

    // Shift raw levels through two flops per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= raw_in;
            sync_out <= meta_q;
        end
    end

endmodule

// File: rtl/oc_period_counter.sv
// Cycle-by-cycle limiter and persistence counter for overcurrent.
// Marks a PWM period as overloaded when overcurrent appears in it, raises
// the truncation request until the period ends, and counts consecutive
// overloaded periods up to LIMIT.
// Assumes: strobe is a single-cycle synchronous pulse; enable low clears all.
module oc_period_counter #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic oc_any,
    input  logic strobe,
    output logic trunc,
    output logic persist,
    output logic quiet_period
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LIMIT);

    logic          trunc_q;
    logic [CW-1:0] cnt_q;
    logic          ev_seen;

    // Overcurrent seen anywhere in the current period so far
    assign ev_seen = trunc_q | oc_any;

    // Track the period flag and the consecutive-period count
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            trunc_q <= 1'b0;
            cnt_q   <= '0;
        end else if (strobe) begin
            trunc_q <= oc_any;
            if (!ev_seen)
                cnt_q <= '0;
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end else begin
            trunc_q <= ev_seen;
        end
    end

    // Outputs toward the state machine and the modulator
    assign trunc        = enable & ev_seen;
    assign persist      = enable & (cnt_q == CNT_MAX);
    assign quiet_period = enable & strobe & ~ev_seen;

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && strobe && !oc_any && !trunc_q) |=> (cnt_q == '0)); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !strobe) |=> $stable(cnt_q)); // R3
    AST_TRUNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (trunc && !strobe) |=> (trunc || !enable)); // R2

endmodule

// File: rtl/guard_fsm.sv
// Fault state machine: decides whether the bridges may switch, which
// shutdowns are held, and what the fault line shows.
// Assumes: all inputs except persist/quiet_period are synchronized levels.
module guard_fsm
    import pstage_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bridge_on,
    input  logic         uv_any,
    input  logic         ots,
    input  logic         oc_any,
    input  logic         persist,
    input  logic         quiet_period,
    output guard_state_e state,
    output logic         active,
    output logic         in_reset,
    output logic         fault_n
);

    guard_state_e nxt;

    // Next-state selection, bridge reset has top priority
    always_comb begin
        nxt = state;
        if (!bridge_on) begin
            nxt = ST_IN_RESET;
        end else begin
            case (state)
                ST_IN_RESET, ST_UV_HOLD: begin
                    if (uv_any)   nxt = ST_UV_HOLD;
                    else if (ots) nxt = ST_OT_LATCHED;
                    else          nxt = ST_RUN;
                end
                ST_OT_LATCHED: nxt = ST_OT_LATCHED;
                ST_OC_LATCHED: begin
                    if (uv_any)   nxt = ST_UV_HOLD;
                    else if (ots) nxt = ST_OT_LATCHED;
                end
                ST_RUN, ST_CURRENT_LIMIT: begin
                    if (uv_any)       nxt = ST_UV_HOLD;
                    else if (ots)     nxt = ST_OT_LATCHED;
                    else if (persist) nxt = ST_OC_LATCHED;
                    else if (state == ST_RUN && oc_any)
                        nxt = ST_CURRENT_LIMIT;
                    else if (state == ST_CURRENT_LIMIT && quiet_period)
                        nxt = ST_RUN;
                end
                default: nxt = ST_IN_RESET;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IN_RESET;
        else        state <= nxt;
    end

    // Output decode from the registered state
    always_comb begin
        active   = (state == ST_RUN) || (state == ST_CURRENT_LIMIT);
        in_reset = (state == ST_IN_RESET);
        fault_n  = !((state == ST_OC_LATCHED) || (state == ST_OT_LATCHED) ||
                     (state == ST_UV_HOLD));
    end

    AST_RESET_FAULT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !bridge_on |=> (fault_n && !active)); // R9
    AST_UV_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_on && uv_any) |=> (!active && !fault_n)); // R1
    AST_OT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OT_LATCHED && bridge_on) |=> (state == ST_OT_LATCHED)); // R7
    AST_OC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OC_LATCHED && bridge_on && !uv_any) |=> (!active && !fault_n)); // R5
    AST_PERSIST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_on && !uv_any && !ots && persist) |=> (state == ST_OC_LATCHED)); // R3

endmodule

// File: rtl/pstage_guard.sv
// Top of the power-stage fault supervisor. Synchronizes the raw flags,
// runs the period limiter and the fault state machine, and fans the
// decisions out to every half-bridge.
// Assumes: pwm_strobe is synchronous to clk; all other inputs may be async.
module pstage_guard
    import pstage_guard_pkg::*;
#(
    parameter int N_HB     = 4,
    parameter int N_SUP    = 3,
    parameter int CL_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bridge_rst_n,
    input  logic              se_mode,
    input  logic [2*N_HB-1:0] oc_flag,
    input  logic              otw_flag,
    input  logic              ots_flag,
    input  logic [N_SUP-1:0]  uv_flag,
    input  logic              pwm_strobe,
    output logic [N_HB-1:0]   hb_en,
    output logic [N_HB-1:0]   hb_hiz,
    output logic [N_HB-1:0]   pulldown_en,
    output logic              cl_trunc,
    output logic              temp_warn,
    output logic              fault_n
);

    localparam int N_FET  = 2 * N_HB;
    localparam int SYNC_W = N_FET + N_SUP + 4;

    logic [SYNC_W-1:0] sync_bus;
    logic [N_FET-1:0]  s_oc;
    logic [N_SUP-1:0]  s_uv;
    logic              s_otw, s_ots, s_se, s_bridge_on;
    logic              oc_any, uv_any;
    logic              active, in_reset, persist, quiet_period;
    guard_state_e      state;

    // One synchronizer bank for every asynchronous input
    flag_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({bridge_rst_n, se_mode, otw_flag, ots_flag, uv_flag, oc_flag}),
        .sync_out (sync_bus)
    );

    // Split the synchronized bus and reduce the per-FET/per-supply flags
    assign {s_bridge_on, s_se, s_otw, s_ots, s_uv, s_oc} = sync_bus;
    assign oc_any = |s_oc;
    assign uv_any = |s_uv;

    // Cycle-by-cycle limiter and persistence counter
    oc_period_counter #(.LIMIT(CL_LIMIT)) u_limit (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (active),
        .oc_any       (oc_any),
        .strobe       (pwm_strobe),
        .trunc        (cl_trunc),
        .persist      (persist),
        .quiet_period (quiet_period)
    );

    // Fault state machine
    guard_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bridge_on    (s_bridge_on),
        .uv_any       (uv_any),
        .ots          (s_ots),
        .oc_any       (oc_any),
        .persist      (persist),
        .quiet_period (quiet_period),
        .state        (state),
        .active       (active),
        .in_reset     (in_reset),
        .fault_n      (fault_n)
    );

    // Per-half-bridge fan-out; bridges are never protected independently
    for (genvar hb = 0; hb < N_HB; hb++) begin : g_bridge
        assign hb_en[hb]       = active;
        assign hb_hiz[hb]      = ~active;
        assign pulldown_en[hb] = in_reset & ~s_se;
    end

    // Warning path passes straight from the synchronizer
    assign temp_warn = s_otw;

    AST_SE_NO_PULLDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        s_se |-> (pulldown_en == '0)); // R10
    AST_LATCHED_NO_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OC_LATCHED) |-> !cl_trunc); // R3

endmodule

// File: tb/pstage_guard_test.sv
`timescale 1ns/1ps
module pstage_guard_test;

    localparam int N_HB  = 4;
    localparam int N_SUP = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bridge_rst_n = 1'b0;
    logic              se_mode = 1'b0;
    logic [2*N_HB-1:0] oc_flag = '0;
    logic              otw_flag = 1'b0;
    logic              ots_flag = 1'b0;
    logic [N_SUP-1:0]  uv_flag = '0;
    logic              pwm_strobe = 1'b0;
    logic [N_HB-1:0]   hb_en, hb_hiz, pulldown_en;
    logic              cl_trunc, temp_warn, fault_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pstage_guard #(.N_HB(N_HB), .N_SUP(N_SUP), .CL_LIMIT(8)) uut (
        .clk(clk), .rst_n(rst_n), .bridge_rst_n(bridge_rst_n), .se_mode(se_mode),
        .oc_flag(oc_flag), .otw_flag(otw_flag), .ots_flag(ots_flag),
        .uv_flag(uv_flag), .pwm_strobe(pwm_strobe),
        .hb_en(hb_en), .hb_hiz(hb_hiz), .pulldown_en(pulldown_en),
        .cl_trunc(cl_trunc), .temp_warn(temp_warn), .fault_n(fault_n)
    );

    // Vector: [10] bridge_rst_n [9] se_mode [8:6] uv [5] ots [4] otw |
    //         [3] exp enable [2] exp fault_n [1] exp pulldown [0] exp warn
    localparam int NV = 14;
    localparam logic [10:0] VEC [NV] = '{
        11'b0_0_000_0_0_0_1_1_0,  // R9 R10 reset, BTL
        11'b0_1_000_0_0_0_1_0_0,  // R10 reset, single-ended
        11'b0_0_111_1_0_0_1_1_0,  // R9 faults masked in reset
        11'b1_0_000_0_0_1_1_0_0,  // R9 release
        11'b1_0_000_0_1_1_1_0_1,  // R6 warning only
        11'b1_0_010_0_1_0_0_0_1,  // R1 R8 undervoltage
        11'b1_0_000_0_0_1_1_0_0,  // R8 self recovery
        11'b1_0_000_1_0_0_0_0_0,  // R1 R7 temperature shutdown
        11'b1_0_000_0_0_0_0_0_0,  // R7 held after flag clears
        11'b0_0_000_0_0_0_1_1_0,  // R7 R9 bridge reset
        11'b1_0_000_0_0_1_1_0_0,  // R7 resumes
        11'b0_1_100_0_0_0_1_0_0,  // R9 R10 reset with UV, single-ended
        11'b1_1_100_0_0_0_0_0_0,  // R8 UV after release
        11'b1_1_000_0_0_1_1_0_0   // R8 recovered
    };

    function automatic string vec_tag(int i);
        case (i)
            0, 2, 3:  return "R9";
            1, 11:    return "R10";
            4:        return "R6";
            5, 6:     return "R8";
            7:        return "R1";
            default:  return (i <= 10) ? "R7" : "R8";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    // One PWM period: strobe for one cycle, then three idle cycles
    task automatic period();
        @(negedge clk) pwm_strobe = 1'b1;
        @(negedge clk) pwm_strobe = 1'b0;
        tick(2);
    endtask

    task automatic expect_bridges(string tag, bit en, bit fn);
        check(tag, {hb_en, hb_hiz}, {{N_HB{en}}, {N_HB{~en}}});
        check(tag, fault_n, fn);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: outputs during logic reset
        tick(3);
        check("R12", {hb_en, hb_hiz, pulldown_en}, {{N_HB{1'b0}}, {N_HB{1'b1}}, {N_HB{1'b1}}});
        check("R12", {fault_n, temp_warn, cl_trunc}, 3'b100);
        rst_n = 1'b1;
        tick(2);

        // Table of static flag patterns
        for (int i = 0; i < NV; i++) begin
            bridge_rst_n = VEC[i][10];
            se_mode      = VEC[i][9];
            uv_flag      = VEC[i][8:6];
            ots_flag     = VEC[i][5];
            otw_flag     = VEC[i][4];
            tick(6);
            expect_bridges(vec_tag(i), VEC[i][3], VEC[i][2]);
            check(vec_tag(i), {pulldown_en, temp_warn},
                  {{N_HB{VEC[i][1]}}, VEC[i][0]});
        end

        // Directed: limiting, count restart, shutdown and release
        se_mode = 1'b0;
        tick(6);
        oc_flag = 8'b0000_1000;
        tick(4);
        check("R2", cl_trunc, 1'b1);
        expect_bridges("R2", 1'b1, 1'b1);
        repeat (5) period();
        oc_flag = '0;
        tick(4);
        check("R2", cl_trunc, 1'b1);          // held to end of period
        period();
        check("R2", cl_trunc, 1'b0);
        period();                              // quiet period clears count
        oc_flag = 8'b0100_0000;
        tick(4);
        repeat (7) period();
        expect_bridges("R4", 1'b1, 1'b1);
        period();
        tick(2);
        expect_bridges("R3", 1'b0, 1'b0);
        check("R3", cl_trunc, 1'b0);
        oc_flag = '0;
        tick(4);
        repeat (3) period();
        expect_bridges("R5", 1'b0, 1'b0);
        bridge_rst_n = 1'b0;
        tick(6);
        expect_bridges("R9", 1'b0, 1'b1);
        check("R10", pulldown_en, {N_HB{1'b1}});
        bridge_rst_n = 1'b1;
        tick(6);
        expect_bridges("R5", 1'b1, 1'b1);

        // Directed: undervoltage clears an overcurrent shutdown
        oc_flag = 8'b0000_0001;
        tick(4);
        repeat (8) period();
        tick(2);
        expect_bridges("R11", 1'b0, 1'b0);
        uv_flag = 3'b001;
        oc_flag = '0;
        tick(6);
        expect_bridges("R11", 1'b0, 1'b0);
        uv_flag = '0;
        tick(6);
        expect_bridges("R11", 1'b1, 1'b1);
        check("R11", cl_trunc, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule